// File: doc/BRIEF.md
# Egress Traffic-Class Scheduler with Two-Level Priority Mapping

This block decides which of eight traffic-class queues sends the next frame on one egress port. It has two independent parts. The classifier takes a frame's priority fields and turns them into one of sixteen internal switch priorities. Depending on a selector, it uses either the VLAN priority (optionally widened by the CFI bit) or the DSCP code point, and the lookup goes through a programmable table. A second programmable table then turns that switch priority into a traffic class, which is what the queueing logic uses to place the frame.

The scheduler sees, for each class, whether its queue holds a frame and the length of the frame at its head. Each class is set either to strict service or to deficit-weighted round robin with its own quantum. When the egress side signals a frame boundary, the scheduler issues a one-cycle grant that names the class allowed to send. Strict classes always go first. The remaining classes share the port in proportion to their quanta.

Queue storage, frame transfer and the MAC are outside this block.

Top module: `egress_tc_sched`

## Requirements
- R1: After reset, `grant_valid_o` and `cls_valid_o` are 0.
- R2: With `cfg_use_dscp_i`=0, the switch priority is the 4-bit field at bits [4*i+3:4*i] of `cfg_vlan_map_i`. The index i is the PCP value when `cfg_cfi_ext_i`=0, in which case the CFI bit has no effect. When `cfg_cfi_ext_i`=1, i is {PCP, CFI}, with the PCP in i[3:1] and the CFI in i[0]. The result appears on `cls_swpri_o` with `cls_valid_o` one clock after `cls_valid_i` is sampled high.
- R3: With `cfg_use_dscp_i`=1, the switch priority is the field at bits [4*d+3:4*d] of `cfg_dscp_map_i`, where d is the 6-bit DSCP value. This result has the same one-clock timing as R2.
- R4: The traffic class on `cls_tc_o` is the 3-bit field at bits [3*p+2:3*p] of `cfg_tc_map_i`, where p is the switch priority output in the same cycle.
- R5: A grant is a one-cycle pulse. It appears only in the cycle after a cycle in which `port_ready_i` was 1 and no grant was out. Two grants never come back to back.
- R6: While any class whose bit in `cfg_strict_i` is 1 has a frame, the grant goes to the highest-numbered such class, one clock after the decision cycle.
- R7: Non-strict classes take turns in descending class order, wrapping from 0 to 7. The first turn after reset goes to the highest eligible class. A class gains its quantum (bits [12*c+11:12*c] of `cfg_quantum_i`) when its turn comes, and it keeps its turn and is granted while its deficit is at least its head length. That length is then subtracted from the deficit. Each turn advance costs one clock before the grant.
- R8: The deficit of a class whose queue is empty is cleared to 0, so a refilled class starts its next turn with only its quantum.
- R9: With every queue empty, no grant is issued however long `port_ready_i` stays high.
- R10: A grant only ever names a class whose queue was non-empty in the decision cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cls_valid_i | input | 1 | A frame's priority fields are present |
| cls_pcp_i | input | 3 | VLAN priority code point |
| cls_cfi_i | input | 1 | VLAN CFI / DEI bit |
| cls_dscp_i | input | 6 | DSCP code point |
| cfg_use_dscp_i | input | 1 | 1: DSCP is the priority source, 0: VLAN |
| cfg_cfi_ext_i | input | 1 | 1: CFI widens the VLAN index to 16 levels |
| cfg_vlan_map_i | input | 64 | VLAN index to switch priority table, 4 bits per entry |
| cfg_dscp_map_i | input | 256 | DSCP to switch priority table, 4 bits per entry |
| cfg_tc_map_i | input | 48 | Switch priority to class table, 3 bits per entry |
| cls_valid_o | output | 1 | Classification result valid |
| cls_swpri_o | output | 4 | Switch priority |
| cls_tc_o | output | 3 | Traffic class |
| port_ready_i | input | 1 | Egress is at a frame boundary and can take a grant |
| q_nonempty_i | input | 8 | Per-class queue holds a frame |
| q_head_len_i | input | 96 | Per-class head frame length, 12 bits per class |
| cfg_strict_i | input | 8 | Per-class strict-service select |
| cfg_quantum_i | input | 96 | Per-class quantum, 12 bits per class |
| grant_valid_o | output | 1 | Grant pulse |
| grant_tc_o | output | 3 | Class granted |

## Verification
The classifier result is due exactly one clock after its input is sampled. The bench drives on a falling edge and compares on the next falling edge, across every PCP/CFI combination in both VLAN widths and all 64 DSCP values. A strict grant is due one clock after the ready cycle. A round-robin grant is due one clock plus one clock for each turn advance. The bench's arithmetic deficit model predicts both the class and that advance count, and the bench measures the actual latency in clocks against the prediction. After each grant the bench drops ready, updates the queue flags, and confirms that the following cycle carries no grant.

// File: rtl/tcs_pkg.sv
// Shared definitions for the egress traffic-class scheduler.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tcs_pkg;
    // Decision taken by the scheduler in one cycle
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_STRICT  = 2'd1,
        ACT_SEND    = 2'd2,
        ACT_ADVANCE = 2'd3
    } sched_act_e;
endpackage

// File: rtl/tcs_prio_map.sv
// Two-level priority classifier.
// The first level maps the VLAN index or the DSCP value to a switch
// priority; the second level maps that priority to a traffic class.
// The output is registered, so a result follows its input by one clock.
// Assumes 2**(PCP_W+1) == NUM_SWPRI, so that a CFI-widened index covers
// the whole VLAN table.
module tcs_prio_map #(
    parameter int unsigned PCP_W     = 3,
    parameter int unsigned DSCP_W    = 6,
    parameter int unsigned NUM_SWPRI = 16,
    parameter int unsigned TC_W      = 3,
    localparam int unsigned SP_W     = $clog2(NUM_SWPRI),
    localparam int unsigned VLAN_N   = 2 ** (PCP_W + 1),
    localparam int unsigned DSCP_N   = 2 ** DSCP_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [PCP_W-1:0]            in_pcp,
    input  logic                        in_cfi,
    input  logic [DSCP_W-1:0]           in_dscp,
    input  logic                        cfg_use_dscp,
    input  logic                        cfg_cfi_ext,
    input  logic [VLAN_N*SP_W-1:0]      cfg_vlan_map,
    input  logic [DSCP_N*SP_W-1:0]      cfg_dscp_map,
    input  logic [NUM_SWPRI*TC_W-1:0]   cfg_tc_map,
    output logic                        out_valid,
    output logic [SP_W-1:0]             out_swpri,
    output logic [TC_W-1:0]             out_tc
);
    logic [PCP_W:0]   vlan_idx;
    logic [SP_W-1:0]  swpri_c;
    logic [TC_W-1:0]  tc_c;

    // Look up the switch priority from the selected source, then the class
    always_comb begin
        vlan_idx = cfg_cfi_ext ? {in_pcp, in_cfi} : {1'b0, in_pcp};
        if (cfg_use_dscp)
            swpri_c = cfg_dscp_map[int'(in_dscp) * SP_W +: SP_W];
        else
            swpri_c = cfg_vlan_map[int'(vlan_idx) * SP_W +: SP_W];
        tc_c = cfg_tc_map[int'(swpri_c) * TC_W +: TC_W];
    end

    // Register the classification result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_swpri <= '0;
            out_tc    <= '0;
        end else begin
            out_valid <= in_valid;
            out_swpri <= swpri_c;
            out_tc    <= tc_c;
        end
    end

    AST_CLS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !$past(in_valid) |-> !out_valid) else $error("classifier result without input"); // R2
endmodule

// File: rtl/tcs_dwrr_engine.sv
// Grant engine: strict classes first (highest number wins); the remaining
// classes are served by deficit-weighted round robin in descending order.
// A decision is taken in any cycle with port_ready high and no grant out.
// Each decision either grants (output registered, one clock later) or
// advances the round-robin turn, adding the new class's quantum.
// Assumes NUM_TC is a power of two and every quantum is non-zero.
module tcs_dwrr_engine
    import tcs_pkg::*;
#(
    parameter int unsigned NUM_TC = 8,
    parameter int unsigned LEN_W  = 12,
    parameter int unsigned QNT_W  = 12,
    localparam int unsigned TC_W  = $clog2(NUM_TC),
    localparam int unsigned DEF_W = ((LEN_W > QNT_W) ? LEN_W : QNT_W) + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      port_ready,
    input  logic [NUM_TC-1:0]         q_nonempty,
    input  logic [NUM_TC*LEN_W-1:0]   q_head_len,
    input  logic [NUM_TC-1:0]         cfg_strict,
    input  logic [NUM_TC*QNT_W-1:0]   cfg_quantum,
    output logic                      grant_valid,
    output logic [TC_W-1:0]           grant_tc
);
    logic [DEF_W-1:0]  deficit_q [NUM_TC];
    logic [TC_W-1:0]   cur_q;
    logic              turn_on_q;

    logic [NUM_TC-1:0] strict_elig;
    logic [NUM_TC-1:0] drr_elig;
    logic [TC_W-1:0]   top_strict;
    logic [TC_W-1:0]   next_tc;
    logic [TC_W-1:0]   cand;
    logic              found;
    logic [DEF_W-1:0]  def_cur;
    logic [DEF_W-1:0]  len_cur;
    logic              decide;
    sched_act_e        act;

    // Find the top strict class and the next round-robin class below cur_q
    always_comb begin
        strict_elig = q_nonempty & cfg_strict;
        drr_elig    = q_nonempty & ~cfg_strict;
        top_strict  = '0;
        for (int i = 0; i < NUM_TC; i++)
            if (strict_elig[i]) top_strict = TC_W'(i);
        next_tc = cur_q;
        found   = 1'b0;
        cand    = '0;
        for (int k = 1; k <= NUM_TC; k++) begin
            cand = TC_W'(int'(cur_q) - k);
            if (!found && drr_elig[cand]) begin
                next_tc = cand;
                found   = 1'b1;
            end
        end
    end

    // Choose this cycle's action
    always_comb begin
        def_cur = deficit_q[cur_q];
        len_cur = {{(DEF_W-LEN_W){1'b0}}, q_head_len[int'(cur_q) * LEN_W +: LEN_W]};
        decide  = port_ready && !grant_valid;
        if (!decide)
            act = ACT_IDLE;
        else if (strict_elig != '0)
            act = ACT_STRICT;
        else if (drr_elig == '0)
            act = ACT_IDLE;
        else if (turn_on_q && drr_elig[cur_q] && (def_cur >= len_cur))
            act = ACT_SEND;
        else
            act = ACT_ADVANCE;
    end

    // Per-class deficit counters
    for (genvar c = 0; c < NUM_TC; c++) begin : g_def
        // Clear when empty or strict, subtract on send, add quantum on turn
        always_ff @(posedge clk) begin
            if (!rst_n)
                deficit_q[c] <= '0;
            else if (!q_nonempty[c] || cfg_strict[c])
                deficit_q[c] <= '0;
            else if (act == ACT_SEND && int'(cur_q) == c)
                deficit_q[c] <= deficit_q[c] - len_cur;
            else if (act == ACT_ADVANCE && int'(next_tc) == c)
                deficit_q[c] <= deficit_q[c] + DEF_W'(cfg_quantum[c*QNT_W +: QNT_W]);
        end

        AST_DEF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) ($past(q_nonempty[c]) == 1'b0) |-> (deficit_q[c] == '0)) else $error("deficit kept on empty class"); // R8
    end

    // Round-robin turn pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            turn_on_q <= 1'b0;
        end else if (act == ACT_ADVANCE) begin
            cur_q     <= next_tc;
            turn_on_q <= 1'b1;
        end
    end

    // Registered grant pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_tc    <= '0;
        end else begin
            grant_valid <= (act == ACT_STRICT) || (act == ACT_SEND);
            grant_tc    <= (act == ACT_STRICT) ? top_strict : cur_q;
        end
    end

    AST_GRANT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) grant_valid |-> ($past(port_ready) && !$past(grant_valid))) else $error("grant outside frame boundary"); // R5
    AST_GRANT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) grant_valid |-> ((($past(q_nonempty) >> grant_tc) & NUM_TC'(1)) != '0)) else $error("grant to empty class"); // R10
    AST_STRICT_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (grant_valid && ($past(q_nonempty & cfg_strict) != '0)) |-> ((($past(cfg_strict) >> grant_tc) & NUM_TC'(1)) != '0)) else $error("round-robin class beat strict class"); // R6
    AST_DRR_FUNDED: assert property (@(posedge clk) disable iff (!rst_n) (grant_valid && ($past(strict_elig) == '0)) |-> ($past(def_cur) >= $past(len_cur))) else $error("round-robin grant without deficit"); // R7
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) ($past(q_nonempty) == '0) |-> !grant_valid) else $error("grant with all queues empty"); // R9
endmodule

// File: rtl/egress_tc_sched.sv
// Egress traffic-class scheduler top: a two-level priority classifier and
// a strict / deficit-weighted round-robin grant engine for one port.
// The two parts share clock and reset only; the classifier feeds the
// queueing logic outside this block, which in turn feeds the engine.
module egress_tc_sched #(
    parameter int unsigned NUM_TC    = 8,
    parameter int unsigned NUM_SWPRI = 16,
    parameter int unsigned PCP_W     = 3,
    parameter int unsigned DSCP_W    = 6,
    parameter int unsigned LEN_W     = 12,
    parameter int unsigned QNT_W     = 12,
    localparam int unsigned TC_W     = $clog2(NUM_TC),
    localparam int unsigned SP_W     = $clog2(NUM_SWPRI),
    localparam int unsigned VLAN_N   = 2 ** (PCP_W + 1),
    localparam int unsigned DSCP_N   = 2 ** DSCP_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cls_valid_i,
    input  logic [PCP_W-1:0]            cls_pcp_i,
    input  logic                        cls_cfi_i,
    input  logic [DSCP_W-1:0]           cls_dscp_i,
    input  logic                        cfg_use_dscp_i,
    input  logic                        cfg_cfi_ext_i,
    input  logic [VLAN_N*SP_W-1:0]      cfg_vlan_map_i,
    input  logic [DSCP_N*SP_W-1:0]      cfg_dscp_map_i,
    input  logic [NUM_SWPRI*TC_W-1:0]   cfg_tc_map_i,
    output logic                        cls_valid_o,
    output logic [SP_W-1:0]             cls_swpri_o,
    output logic [TC_W-1:0]             cls_tc_o,
    input  logic                        port_ready_i,
    input  logic [NUM_TC-1:0]           q_nonempty_i,
    input  logic [NUM_TC*LEN_W-1:0]     q_head_len_i,
    input  logic [NUM_TC-1:0]           cfg_strict_i,
    input  logic [NUM_TC*QNT_W-1:0]     cfg_quantum_i,
    output logic                        grant_valid_o,
    output logic [TC_W-1:0]             grant_tc_o
);
    tcs_prio_map #(
        .PCP_W     (PCP_W),
        .DSCP_W    (DSCP_W),
        .NUM_SWPRI (NUM_SWPRI),
        .TC_W      (TC_W)
    ) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (cls_valid_i),
        .in_pcp       (cls_pcp_i),
        .in_cfi       (cls_cfi_i),
        .in_dscp      (cls_dscp_i),
        .cfg_use_dscp (cfg_use_dscp_i),
        .cfg_cfi_ext  (cfg_cfi_ext_i),
        .cfg_vlan_map (cfg_vlan_map_i),
        .cfg_dscp_map (cfg_dscp_map_i),
        .cfg_tc_map   (cfg_tc_map_i),
        .out_valid    (cls_valid_o),
        .out_swpri    (cls_swpri_o),
        .out_tc       (cls_tc_o)
    );

    tcs_dwrr_engine #(
        .NUM_TC (NUM_TC),
        .LEN_W  (LEN_W),
        .QNT_W  (QNT_W)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_ready  (port_ready_i),
        .q_nonempty  (q_nonempty_i),
        .q_head_len  (q_head_len_i),
        .cfg_strict  (cfg_strict_i),
        .cfg_quantum (cfg_quantum_i),
        .grant_valid (grant_valid_o),
        .grant_tc    (grant_tc_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) $past(!rst_n) |-> (!grant_valid_o && !cls_valid_o)) else $error("outputs active after reset"); // R1
endmodule

// File: tb/tb_egress_tc_sched.sv
// Self-checking bench: full classifier sweep plus scheduler scenarios
// checked against an arithmetic deficit model.
module tb_egress_tc_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NTC = 8;
    localparam int LW  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cls_valid_i = 1'b0;
    logic [2:0] cls_pcp_i = '0;
    logic cls_cfi_i = 1'b0;
    logic [5:0] cls_dscp_i = '0;
    logic cfg_use_dscp_i = 1'b0;
    logic cfg_cfi_ext_i = 1'b0;
    logic [63:0] cfg_vlan_map_i = '0;
    logic [255:0] cfg_dscp_map_i = '0;
    logic [47:0] cfg_tc_map_i = '0;
    logic cls_valid_o;
    logic [3:0] cls_swpri_o;
    logic [2:0] cls_tc_o;
    logic port_ready_i = 1'b0;
    logic [7:0] q_nonempty_i = '0;
    logic [95:0] q_head_len_i = '0;
    logic [7:0] cfg_strict_i = '0;
    logic [95:0] cfg_quantum_i = '0;
    logic grant_valid_o;
    logic [2:0] grant_tc_o;

    int n_tests = 0;
    int n_fail = 0;

    // bench-side queue and deficit model
    int cnt  [NTC];
    int mlen [NTC];
    int mq   [NTC];
    int mdef [NTC];
    int mcur;
    bit mon;

    always #(CLK_PERIOD/2) clk = ~clk;

    egress_tc_sched dut (
        .clk(clk), .rst_n(rst_n),
        .cls_valid_i(cls_valid_i), .cls_pcp_i(cls_pcp_i), .cls_cfi_i(cls_cfi_i),
        .cls_dscp_i(cls_dscp_i), .cfg_use_dscp_i(cfg_use_dscp_i),
        .cfg_cfi_ext_i(cfg_cfi_ext_i), .cfg_vlan_map_i(cfg_vlan_map_i),
        .cfg_dscp_map_i(cfg_dscp_map_i), .cfg_tc_map_i(cfg_tc_map_i),
        .cls_valid_o(cls_valid_o), .cls_swpri_o(cls_swpri_o), .cls_tc_o(cls_tc_o),
        .port_ready_i(port_ready_i), .q_nonempty_i(q_nonempty_i),
        .q_head_len_i(q_head_len_i), .cfg_strict_i(cfg_strict_i),
        .cfg_quantum_i(cfg_quantum_i), .grant_valid_o(grant_valid_o),
        .grant_tc_o(grant_tc_o)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_q();
        for (int c = 0; c < NTC; c++) begin
            q_nonempty_i[c] = (cnt[c] != 0);
            q_head_len_i[c*LW +: LW] = mlen[c][LW-1:0];
            cfg_quantum_i[c*LW +: LW] = mq[c][LW-1:0];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        port_ready_i = 1'b0;
        for (int c = 0; c < NTC; c++) mdef[c] = 0;
        mcur = 0;
        mon = 1'b0;
        drive_q();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Model of the expected grant: class (-1 when none) and turn advances
    task automatic model_pick(output int tc, output int adv);
        int top;
        bit any_drr;
        bit done;
        tc = -1;
        adv = 0;
        top = -1;
        any_drr = 1'b0;
        for (int c = 0; c < NTC; c++) begin
            if (cnt[c] != 0 && cfg_strict_i[c]) top = c;
            if (cnt[c] != 0 && !cfg_strict_i[c]) any_drr = 1'b1;
        end
        if (top >= 0) begin
            tc = top;
            return;
        end
        if (!any_drr) return;
        done = 1'b0;
        while (!done) begin
            if (mon && cnt[mcur] != 0 && !cfg_strict_i[mcur] && mdef[mcur] >= mlen[mcur]) begin
                mdef[mcur] -= mlen[mcur];
                tc = mcur;
                done = 1'b1;
            end else begin
                for (int k = 1; k <= NTC; k++) begin
                    int cd;
                    cd = (mcur - k + 2*NTC) % NTC;
                    if (cnt[cd] != 0 && !cfg_strict_i[cd]) begin
                        mcur = cd;
                        break;
                    end
                end
                mdef[mcur] += mq[mcur];
                mon = 1'b1;
                adv++;
            end
        end
    endtask

    // Request one grant and compare class and latency with the model
    task automatic one_grant(input string req);
        int exp_tc;
        int adv;
        int waited;
        model_pick(exp_tc, adv);
        port_ready_i = 1'b1;
        if (exp_tc < 0) begin
            int seen;
            seen = 0;
            repeat (6) begin
                @(posedge clk);
                @(negedge clk);
                if (grant_valid_o) seen++;
            end
            port_ready_i = 1'b0;
            check(seen == 0, "R9", "grants with all empty", seen, 0);
            return;
        end
        waited = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            waited++;
        end while (!grant_valid_o && waited < 60);
        port_ready_i = 1'b0;
        check(grant_valid_o == 1'b1 && int'(grant_tc_o) == exp_tc, req, "granted class", int'(grant_tc_o), exp_tc);
        check(waited == adv + 1, req, "grant latency", waited, adv + 1);
        cnt[exp_tc]--;
        if (cnt[exp_tc] == 0) mdef[exp_tc] = 0;
        drive_q();
        @(posedge clk);
        @(negedge clk);
        check(grant_valid_o == 1'b0, "R5", "grant pulse width", int'(grant_valid_o), 0);
    endtask

    task automatic set_q(input int c, input int n, input int len, input int q);
        cnt[c] = n;
        mlen[c] = len;
        mq[c] = q;
    endtask

    task automatic clear_q();
        for (int c = 0; c < NTC; c++) set_q(c, 0, 64, 256);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        clear_q();
        do_reset();
        @(negedge clk);
        // r1_ reset state
        check(grant_valid_o == 1'b0, "R1", "grant after reset", int'(grant_valid_o), 0);
        check(cls_valid_o == 1'b0, "R1", "class valid after reset", int'(cls_valid_o), 0);

        // classifier tables computed arithmetically
        for (int i = 0; i < 16; i++) cfg_vlan_map_i[i*4 +: 4] = 4'((5*i + 3) % 16);
        for (int d = 0; d < 64; d++) cfg_dscp_map_i[d*4 +: 4] = 4'((7*d + 1 + d/16) % 16);
        for (int p = 0; p < 16; p++) cfg_tc_map_i[p*3 +: 3] = 3'((3*p + 2) % 8);

        // R2: 8-level VLAN, CFI must not matter
        cfg_use_dscp_i = 1'b0;
        cfg_cfi_ext_i = 1'b0;
        for (int v = 0; v < 16; v++) begin
            int sp;
            cls_valid_i = 1'b1;
            cls_pcp_i = 3'(v >> 1);
            cls_cfi_i = v[0];
            cls_dscp_i = 6'(v * 3);
            sp = (5*(v >> 1) + 3) % 16;
            @(posedge clk);
            @(negedge clk);
            check(cls_valid_o && int'(cls_swpri_o) == sp, "R2", "vlan8 swpri", int'(cls_swpri_o), sp);
            check(int'(cls_tc_o) == (3*sp + 2) % 8, "R4", "vlan8 class", int'(cls_tc_o), (3*sp + 2) % 8);
        end
        // R2: 16-level VLAN with CFI as low index bit
        cfg_cfi_ext_i = 1'b1;
        for (int v = 0; v < 16; v++) begin
            int sp;
            cls_pcp_i = 3'(v >> 1);
            cls_cfi_i = v[0];
            sp = (5*v + 3) % 16;
            @(posedge clk);
            @(negedge clk);
            check(cls_valid_o && int'(cls_swpri_o) == sp, "R2", "vlan16 swpri", int'(cls_swpri_o), sp);
            check(int'(cls_tc_o) == (3*sp + 2) % 8, "R4", "vlan16 class", int'(cls_tc_o), (3*sp + 2) % 8);
        end
        // R3: DSCP source, all 64 code points
        cfg_use_dscp_i = 1'b1;
        for (int d = 0; d < 64; d++) begin
            int sp;
            cls_dscp_i = 6'(d);
            cls_pcp_i = 3'(d % 8);
            sp = (7*d + 1 + d/16) % 16;
            @(posedge clk);
            @(negedge clk);
            check(cls_valid_o && int'(cls_swpri_o) == sp, "R3", "dscp swpri", int'(cls_swpri_o), sp);
            check(int'(cls_tc_o) == (3*sp + 2) % 8, "R4", "dscp class", int'(cls_tc_o), (3*sp + 2) % 8);
        end
        cls_valid_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(cls_valid_o == 1'b0, "R2", "valid follows input", int'(cls_valid_o), 0);

        // R9: nothing queued
        cfg_strict_i = 8'h00;
        clear_q();
        do_reset();
        one_grant("R9");

        // R6: all classes strict
        cfg_strict_i = 8'hFF;
        clear_q();
        set_q(0, 2, 64, 256);
        set_q(3, 2, 64, 256);
        set_q(7, 2, 64, 256);
        do_reset();
        for (int g = 0; g < 7; g++) one_grant("R6");

        // R6/R7/R10: mixed strict and round-robin classes
        cfg_strict_i = 8'h42;
        clear_q();
        set_q(1, 2, 64, 256);
        set_q(6, 1, 64, 256);
        set_q(0, 3, 200, 256);
        set_q(2, 2, 500, 256);
        set_q(5, 4, 150, 512);
        set_q(7, 3, 400, 256);
        do_reset();
        for (int g = 0; g < 16; g++) one_grant("R7");

        // R7: lengths above quantum force several turns
        cfg_strict_i = 8'h00;
        clear_q();
        set_q(3, 3, 300, 100);
        set_q(4, 3, 300, 100);
        set_q(7, 4, 50, 100);
        do_reset();
        for (int g = 0; g < 11; g++) one_grant("R7");

        // R8: emptied class loses its leftover deficit
        clear_q();
        set_q(7, 1, 600, 1000);
        set_q(2, 4, 150, 200);
        do_reset();
        one_grant("R8");
        one_grant("R8");
        cnt[7] = 2;
        drive_q();
        for (int g = 0; g < 7; g++) one_grant("R8");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule